// File: doc/BRIEF.md
# Banked Multi-Port Data Memory

This block is the 64 KB local data store of a compute tile. It is built from eight single-port banks of 512 rows by 128 bits and is shared by three access ports: two load ports and one store port. The banks are grouped in pairs, one even and one odd, and each pair acts as a double bank. A 256-bit vector access uses both banks of one pair at the same row. A scalar access touches a single 32-bit word in one bank. Data is little-endian: the lowest byte address holds the least significant byte.

Each cycle the block decodes every request to the set of banks it needs. It grants together all requests whose bank sets do not overlap. On a clash the store port wins first, then load port 0, then load port 1. A port that loses sees its ready low and holds its request until ready rises. The banks only move whole 32-bit words, so a byte or halfword store is done as a read followed by a merged write. This keeps the store port busy for two cycles. Load data comes back one cycle after the grant, with a valid flag. A misaligned request is refused with an error flag and never touches the memory.

The store port is controlled by a two-state machine. `ST_IDLE` accepts a request. A word or vector store writes in that same cycle and raises ready. A misaligned vector store raises ready and error and does no access. A byte or halfword store reads the enclosing word and takes the transition `ST_IDLE -> ST_MERGE`. `ST_MERGE` writes the merged word, raises ready and always returns to `ST_IDLE`.

Top module: `dm_banked_mem`

## Requirements
- R1: Bank index is {addr[6:5], addr[4]}, row is addr[15:7], and addr[3:0] is the byte offset in a 128-bit bank word. A vector access at a 32-byte aligned address covers both banks of pair addr[6:5]: bytes 0 to 15 are in the even bank and bytes 16 to 31 are in the odd bank.
- R2: Memory is little-endian. A byte written at address A appears in bits [8*(A mod 4)+7 : 8*(A mod 4)] of the 32-bit word loaded from A with its two low bits cleared.
- R3: Store, load 0 and load 1 requests whose bank sets do not overlap are all granted in the same cycle. Ready is high on every such port.
- R4: When bank sets overlap, the store port wins over load 0 and load 0 wins over load 1. A losing port has ready low, and it is granted in a later cycle while it keeps its request.
- R5: A granted load raises its rvalid in the next cycle. Rdata then holds the 32 bytes for a vector load (ld_vec=1), or the addressed 32-bit word in bits 31:0 with bits 255:32 zero for a scalar load.
- R6: st_size encodes 0 = byte, 1 = halfword, 2 = word and 3 = vector. A byte or halfword store keeps st_rdy low in its first cycle and high in its second cycle. Only the addressed bytes change.
- R7: A byte store writes st_wdata[7:0] at addr. A halfword store writes st_wdata[15:0] into the half of the word chosen by addr[1]; addr[0] is ignored. A word store writes st_wdata[31:0] into the word at addr with bits 1:0 cleared. A vector store completes in one cycle.
- R8: A vector request whose addr[4:0] is not zero, or a scalar load whose addr[1:0] is not zero, gets ready and error in the same cycle. It performs no access, leaves the memory unchanged and produces no rvalid.
- R9: With reset asserted and no request, every ready, error and rvalid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req | input | 1 | Store request, held until st_rdy |
| st_size | input | 2 | Store size: 0 byte, 1 half, 2 word, 3 vector |
| st_addr | input | 16 | Store byte address |
| st_wdata | input | 256 | Store data, right-aligned for scalar stores |
| st_rdy | output | 1 | Store accepted and completed this cycle |
| st_err | output | 1 | Store refused because it is misaligned |
| ld0_req | input | 1 | Load port 0 request |
| ld0_vec | input | 1 | Load port 0: 1 = 256-bit vector, 0 = 32-bit scalar |
| ld0_addr | input | 16 | Load port 0 byte address |
| ld0_rdy | output | 1 | Load port 0 granted or refused this cycle |
| ld0_err | output | 1 | Load port 0 refused because it is misaligned |
| ld0_rvalid | output | 1 | Load port 0 data valid |
| ld0_rdata | output | 256 | Load port 0 data |
| ld1_req | input | 1 | Load port 1 request |
| ld1_vec | input | 1 | Load port 1: 1 = vector, 0 = scalar |
| ld1_addr | input | 16 | Load port 1 byte address |
| ld1_rdy | output | 1 | Load port 1 granted or refused this cycle |
| ld1_err | output | 1 | Load port 1 refused because it is misaligned |
| ld1_rvalid | output | 1 | Load port 1 data valid |
| ld1_rdata | output | 256 | Load port 1 data |

## Verification
The bench drives all three ports at once into distinct banks. A decoder that ignored bit 4 or the pair bits would report false clashes, or would return data from the wrong bank. A three-way clash on bank 0 checks the order of grants and that a load behind a store sees the new data. A swapped priority or a lost held request would show up as a wrong ready pattern. The bench also writes a byte and a halfword, with addr[0] set, into known words. A design that skipped the read phase or picked the wrong lanes would corrupt the neighbouring bytes or finish in one cycle. Misaligned vector and scalar requests are sent to regions whose contents the bench knows. A design that still performed them would change that data or raise rvalid.

// File: rtl/dm_pkg.sv
package dm_pkg;
    localparam int ADDR_W  = 16;
    localparam int NBANK   = 8;
    localparam int ROWS    = 512;
    localparam int BANK_W  = 128;
    localparam int VEC_W   = 2 * BANK_W;
    localparam int WORD_W  = 32;
    localparam int NWORD   = BANK_W / WORD_W;
    localparam int BSEL_W  = $clog2(NBANK);
    localparam int ROW_W   = $clog2(ROWS);
    localparam int NLOAD   = 2;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_VEC = 2'd3} size_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_MERGE = 1'b1} st_state_e;

    // Banks touched by one access: a vector takes both banks of a pair.
    function automatic logic [NBANK-1:0] bank_mask(input logic vec, input logic [ADDR_W-1:0] a);
        logic [NBANK-1:0] m;
        m = '0;
        if (vec) begin
            m[{a[6:5], 1'b0}] = 1'b1;
            m[{a[6:5], 1'b1}] = 1'b1;
        end else begin
            m[{a[6:5], a[4]}] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dm_bank.sv
module dm_bank #(
    parameter int ROWS  = 512,
    parameter int WIDTH = 128,
    localparam int AW   = $clog2(ROWS),
    localparam int NW   = WIDTH / 32
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [NW-1:0]    wen,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int w = 0; w < NW; w++) begin
                    if (wen[w]) mem[addr][w*32 +: 32] <= wdata[w*32 +: 32];
                end
            end else begin
                q <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/dm_store_ctl.sv
module dm_store_ctl
    import dm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_req,
    input  logic [1:0]          st_size,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [WORD_W-1:0]   st_wword,
    input  logic [WORD_W-1:0]   old_word,
    output logic                st_rdy,
    output logic                st_err,
    output logic                st_active,
    output logic                st_we,
    output logic [WORD_W-1:0]   merged
);
    st_state_e state, nxt;
    logic sub_op, misal;

    assign sub_op = (st_size == SZ_BYTE) || (st_size == SZ_HALF);
    assign misal  = (st_size == SZ_VEC) && (st_addr[4:0] != 5'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state; st_rdy = 1'b0; st_err = 1'b0; st_active = 1'b0; st_we = 1'b0;
        unique case (state)
            ST_IDLE: if (st_req) begin
                if (misal) begin
                    st_rdy = 1'b1; st_err = 1'b1;
                end else if (sub_op) begin
                    st_active = 1'b1; nxt = ST_MERGE;
                end else begin
                    st_active = 1'b1; st_we = 1'b1; st_rdy = 1'b1;
                end
            end
            ST_MERGE: begin
                st_active = 1'b1; st_we = 1'b1; st_rdy = 1'b1; nxt = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        merged = old_word;
        unique case (st_size)
            SZ_BYTE: unique case (st_addr[1:0])
                2'd0: merged[7:0]   = st_wword[7:0];
                2'd1: merged[15:8]  = st_wword[7:0];
                2'd2: merged[23:16] = st_wword[7:0];
                2'd3: merged[31:24] = st_wword[7:0];
            endcase
            SZ_HALF: if (st_addr[1]) merged[31:16] = st_wword[15:0];
                     else            merged[15:0]  = st_wword[15:0];
            default: merged = st_wword;
        endcase
    end

    p_rmw_second_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && st_req && sub_op) |-> (!st_rdy ##1 (st_rdy && st_we)));
    p_misaligned_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_err) |-> (st_rdy && !st_active));
endmodule

// File: rtl/dm_banked_mem.sv
module dm_banked_mem
    import dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [1:0]        st_size,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [VEC_W-1:0]  st_wdata,
    output logic              st_rdy,
    output logic              st_err,
    input  logic              ld0_req,
    input  logic              ld0_vec,
    input  logic [ADDR_W-1:0] ld0_addr,
    output logic              ld0_rdy,
    output logic              ld0_err,
    output logic              ld0_rvalid,
    output logic [VEC_W-1:0]  ld0_rdata,
    input  logic              ld1_req,
    input  logic              ld1_vec,
    input  logic [ADDR_W-1:0] ld1_addr,
    output logic              ld1_rdy,
    output logic              ld1_err,
    output logic              ld1_rvalid,
    output logic [VEC_W-1:0]  ld1_rdata
);
    logic [BANK_W-1:0] bq [NBANK];
    logic              st_active, st_we;
    logic [WORD_W-1:0] merged, old_word;
    logic [NBANK-1:0]  st_use;
    logic [BSEL_W-1:0] st_bank;

    logic              l_req [NLOAD];
    logic              l_vec [NLOAD];
    logic [ADDR_W-1:0] l_addr [NLOAD];
    logic              l_err [NLOAD];
    logic              l_gnt [NLOAD];
    logic [NBANK-1:0]  l_mask [NLOAD];
    logic [NBANK-1:0]  l_use [NLOAD];
    logic              v_q [NLOAD];
    logic              vec_q [NLOAD];
    logic [BSEL_W-1:0] bank_q [NLOAD];
    logic [1:0]        widx_q [NLOAD];
    logic [VEC_W-1:0]  l_rdata [NLOAD];

    assign l_req[0] = ld0_req;  assign l_vec[0] = ld0_vec;  assign l_addr[0] = ld0_addr;
    assign l_req[1] = ld1_req;  assign l_vec[1] = ld1_vec;  assign l_addr[1] = ld1_addr;

    assign st_bank  = {st_addr[6:5], st_addr[4]};
    assign old_word = bq[st_bank][{st_addr[3:2], 5'd0} +: WORD_W];
    assign st_use   = st_active ? bank_mask(st_size == SZ_VEC, st_addr) : '0;

    dm_store_ctl u_st (
        .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_size(st_size), .st_addr(st_addr),
        .st_wword(st_wdata[WORD_W-1:0]), .old_word(old_word), .st_rdy(st_rdy), .st_err(st_err),
        .st_active(st_active), .st_we(st_we), .merged(merged)
    );

    // Fixed priority: store, then load 0, then load 1.
    always_comb begin
        logic [NBANK-1:0] taken;
        taken = st_use;
        for (int p = 0; p < NLOAD; p++) begin
            l_mask[p] = bank_mask(l_vec[p], l_addr[p]);
            l_err[p]  = l_req[p] && (l_vec[p] ? (l_addr[p][4:0] != 5'd0) : (l_addr[p][1:0] != 2'd0));
            l_gnt[p]  = l_req[p] && !l_err[p] && ((l_mask[p] & taken) == '0);
            l_use[p]  = l_gnt[p] ? l_mask[p] : '0;
            taken     = taken | l_use[p];
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic              en, we;
        logic [NWORD-1:0]  wen;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] wdata;

        always_comb begin
            en = 1'b1; we = 1'b0; wen = '0; row = '0; wdata = '0;
            if (st_use[b]) begin
                we  = st_we;
                row = st_addr[ADDR_W-1:7];
                if (st_size == SZ_VEC) begin
                    wen   = '1;
                    wdata = st_wdata[(b % 2)*BANK_W +: BANK_W];
                end else begin
                    wen   = NWORD'(1) << st_addr[3:2];
                    wdata = {NWORD{merged}};
                end
            end else if (l_use[0][b]) begin
                row = l_addr[0][ADDR_W-1:7];
            end else if (l_use[1][b]) begin
                row = l_addr[1][ADDR_W-1:7];
            end else begin
                en = 1'b0;
            end
        end

        dm_bank #(.ROWS(ROWS), .WIDTH(BANK_W)) u_bank (
            .clk(clk), .en(en), .we(we), .wen(wen), .addr(row), .wdata(wdata), .q(bq[b])
        );
    end

    for (genvar p = 0; p < NLOAD; p++) begin : g_ld
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[p] <= 1'b0; vec_q[p] <= 1'b0; bank_q[p] <= '0; widx_q[p] <= '0;
            end else begin
                v_q[p]    <= l_gnt[p];
                vec_q[p]  <= l_vec[p];
                bank_q[p] <= {l_addr[p][6:5], l_addr[p][4]};
                widx_q[p] <= l_addr[p][3:2];
            end
        end

        always_comb begin
            l_rdata[p] = '0;
            if (vec_q[p]) l_rdata[p] = {bq[{bank_q[p][2:1], 1'b1}], bq[{bank_q[p][2:1], 1'b0}]};
            else          l_rdata[p][WORD_W-1:0] = bq[bank_q[p]][{widx_q[p], 5'd0} +: WORD_W];
        end

        p_rvalid_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (l_gnt[p]) |=> v_q[p]);
        p_refused_no_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (l_err[p]) |=> !v_q[p]);
        p_store_beats_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_active && ((l_mask[p] & st_use) != '0)) |-> !l_gnt[p]);
    end

    p_banks_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_use & l_use[0]) == '0) && ((st_use & l_use[1]) == '0) && ((l_use[0] & l_use[1]) == '0));
    p_load0_beats_load1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_gnt[0] && ((l_mask[0] & l_mask[1]) != '0)) |-> !l_gnt[1]);

    assign ld0_rdy = l_gnt[0] || l_err[0];  assign ld0_err = l_err[0];
    assign ld1_rdy = l_gnt[1] || l_err[1];  assign ld1_err = l_err[1];
    assign ld0_rvalid = v_q[0];  assign ld0_rdata = l_rdata[0];
    assign ld1_rvalid = v_q[1];  assign ld1_rdata = l_rdata[1];
endmodule

// File: tb/dm_banked_mem_tb.sv
module dm_banked_mem_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic st_req = 0; logic [1:0] st_size = 0; logic [15:0] st_addr = 0; logic [255:0] st_wdata = 0;
    logic st_rdy, st_err;
    logic ld0_req = 0, ld0_vec = 0; logic [15:0] ld0_addr = 0;
    logic ld0_rdy, ld0_err, ld0_rvalid; logic [255:0] ld0_rdata;
    logic ld1_req = 0, ld1_vec = 0; logic [15:0] ld1_addr = 0;
    logic ld1_rdy, ld1_err, ld1_rvalid; logic [255:0] ld1_rdata;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [7:0] mm [65536];

    always #2 clk = ~clk;

    dm_banked_mem u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_load(input bit vec, input logic [15:0] a);
        logic [255:0] r = '0;
        if (vec) for (int k = 0; k < 32; k++) r[k*8 +: 8] = mm[16'(a + k)];
        else     for (int k = 0; k < 4; k++)  r[k*8 +: 8] = mm[16'({a[15:2], 2'b00} + k)];
        return r;
    endfunction

    function automatic void model_store(input logic [1:0] sz, input logic [15:0] a, input logic [255:0] d);
        case (sz)
            2'd0: mm[a] = d[7:0];
            2'd1: for (int k = 0; k < 2; k++) mm[16'({a[15:1], 1'b0} + k)] = d[k*8 +: 8];
            2'd2: for (int k = 0; k < 4; k++) mm[16'({a[15:2], 2'b00} + k)] = d[k*8 +: 8];
            default: if (a[4:0] == 5'd0) for (int k = 0; k < 32; k++) mm[16'(a + k)] = d[k*8 +: 8];
        endcase
    endfunction

    task automatic do_store(input logic [1:0] sz, input logic [15:0] a, input logic [255:0] d, input string req);
        int cyc = 0;
        bit mis = (sz == 2'd3) && (a[4:0] != 0);
        int exp_cyc = (sz < 2'd2 && !mis) ? 1 : 0;
        @(negedge clk); st_req = 1; st_size = sz; st_addr = a; st_wdata = d;
        #1;
        while (!st_rdy && cyc < 4) begin @(negedge clk); #1; cyc++; end
        chk(cyc == exp_cyc, {req, " store latency"}, 256'(cyc), 256'(exp_cyc));
        chk(st_err == mis, {req, " store err"}, 256'(st_err), 256'(mis));
        model_store(sz, a, d);
        @(posedge clk); #1; st_req = 0;
    endtask

    task automatic do_load(input bit port, input bit vec, input logic [15:0] a, input string req);
        bit mis = vec ? (a[4:0] != 0) : (a[1:0] != 0);
        logic [255:0] e = exp_load(vec, a);
        @(negedge clk);
        if (port) begin ld1_req = 1; ld1_vec = vec; ld1_addr = a; end
        else      begin ld0_req = 1; ld0_vec = vec; ld0_addr = a; end
        #1;
        chk((port ? ld1_rdy : ld0_rdy) == 1'b1, {req, " load rdy"}, 0, 1);
        chk((port ? ld1_err : ld0_err) == mis, {req, " load err"}, 256'(port ? ld1_err : ld0_err), 256'(mis));
        @(posedge clk); #1; ld0_req = 0; ld1_req = 0;
        @(negedge clk); #1;
        chk((port ? ld1_rvalid : ld0_rvalid) == !mis, {req, " rvalid"}, 256'(port ? ld1_rvalid : ld0_rvalid), 256'(!mis));
        if (!mis) chk((port ? ld1_rdata : ld0_rdata) == e, {req, " rdata"}, port ? ld1_rdata : ld0_rdata, e);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [255:0] d, e0, e1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(!st_rdy && !st_err && !ld0_rdy && !ld0_err && !ld1_rdy && !ld1_err && !ld0_rvalid && !ld1_rvalid,
            "R9 reset outputs", 0, 0);
        @(negedge clk); rst_n = 1;

        // Fill the whole memory with vector stores (R7 single-cycle vector).
        for (int a = 0; a < 65536; a += 32) begin
            for (int k = 0; k < 8; k++) d[k*32 +: 32] = $urandom;
            do_store(2'd3, 16'(a), d, "R7 fill");
        end

        // R1: vector layout over even/odd bank of a pair.
        d = {8{32'h0}};
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = 32'h1100_0000 + k;
        do_store(2'd3, 16'h0140, d, "R1 vec");
        for (int k = 0; k < 8; k++) do_load(k[0], 1'b0, 16'(16'h0140 + 4*k), "R1 word");
        do_load(1'b0, 1'b1, 16'h0140, "R1 vec load");

        // R2 / R6 / R7: sub-word stores.
        do_store(2'd2, 16'h200B, 256'h1234_5678, "R7 word");
        do_store(2'd0, 16'h2009, 256'hEE, "R6 byte");
        chk(exp_load(0, 16'h2008) == 256'h1234_EE78, "R2 model", exp_load(0, 16'h2008), 256'h1234_EE78);
        do_load(1'b0, 1'b0, 16'h2008, "R2 byte lane");
        do_store(2'd1, 16'h2013, 256'hBEEF, "R7 half");
        do_load(1'b1, 1'b0, 16'h2010, "R7 half lane");

        // R8: misaligned requests leave memory alone.
        do_store(2'd3, 16'h3008, {8{32'hDEAD_BEEF}}, "R8 vec store");
        do_load(1'b0, 1'b1, 16'h3000, "R8 unchanged");
        do_load(1'b1, 1'b1, 16'h3010, "R8 vec load");
        do_load(1'b0, 1'b0, 16'h3002, "R8 scalar load");

        // R3: three ports, disjoint banks (0; 2; 6+7).
        e0 = exp_load(0, 16'h0024); e1 = exp_load(1, 16'h0060);
        @(negedge clk);
        st_req = 1; st_size = 2'd2; st_addr = 16'h0000; st_wdata = 256'hCAFE_F00D;
        ld0_req = 1; ld0_vec = 0; ld0_addr = 16'h0024;
        ld1_req = 1; ld1_vec = 1; ld1_addr = 16'h0060;
        #1;
        chk(st_rdy && ld0_rdy && ld1_rdy, "R3 all granted", {st_rdy, ld0_rdy, ld1_rdy}, 3'b111);
        model_store(2'd2, 16'h0000, 256'hCAFE_F00D);
        @(posedge clk); #1; st_req = 0; ld0_req = 0; ld1_req = 0;
        @(negedge clk); #1;
        chk(ld0_rvalid && ld0_rdata == e0, "R3 ld0 data", ld0_rdata, e0);
        chk(ld1_rvalid && ld1_rdata == e1, "R3 ld1 data", ld1_rdata, e1);
        do_load(1'b0, 1'b0, 16'h0000, "R3 store landed");

        // R4: everyone on bank 0.
        @(negedge clk);
        st_req = 1; st_size = 2'd2; st_addr = 16'h0404; st_wdata = 256'h0BAD_C0DE;
        ld0_req = 1; ld0_vec = 0; ld0_addr = 16'h0400;
        ld1_req = 1; ld1_vec = 1; ld1_addr = 16'h0400;
        #1;
        chk(st_rdy && !ld0_rdy && !ld1_rdy, "R4 store first", {st_rdy, ld0_rdy, ld1_rdy}, 3'b100);
        model_store(2'd2, 16'h0404, 256'h0BAD_C0DE);
        e0 = exp_load(0, 16'h0400); e1 = exp_load(1, 16'h0400);
        @(posedge clk); #1; st_req = 0;
        @(negedge clk); #1;
        chk(ld0_rdy && !ld1_rdy, "R4 load0 second", {ld0_rdy, ld1_rdy}, 2'b10);
        @(posedge clk); #1; ld0_req = 0;
        @(negedge clk); #1;
        chk(ld0_rvalid && ld0_rdata == e0, "R4 ld0 data", ld0_rdata, e0);
        chk(ld1_rdy, "R4 load1 last", 256'(ld1_rdy), 1);
        @(posedge clk); #1; ld1_req = 0;
        @(negedge clk); #1;
        chk(ld1_rvalid && ld1_rdata == e1, "R4 ld1 data", ld1_rdata, e1);

        // Random mix (R5, R6, R7).
        for (int i = 0; i < 400; i++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic [15:0] a = 16'($urandom);
            bit vec = 1'($urandom);
            for (int k = 0; k < 8; k++) d[k*32 +: 32] = $urandom;
            if (sz == 2'd3 && $urandom_range(0, 9) != 0) a[4:0] = 0;
            do_store(sz, a, d, "R6 random store");
            if (vec) a[4:0] = 0; else a[1:0] = 0;
            if ($urandom_range(0, 1) == 1) a = 16'($urandom) & (vec ? 16'hFFE0 : 16'hFFFC);
            do_load(1'($urandom), vec, a, "R5 random load");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule